// File: doc/BRIEF.md
# Chainable Event Counter Bank with Coherent Wide Read

This block holds a bank of event counters arranged in adjacent pairs. Each counter advances by one for every clock cycle in which its increment input is high and its group-enable bit is set. Any pair can be joined into a single counter of twice the width. In that case the lower counter's roll-over drives the upper counter, and the upper counter no longer responds to its own increment input.

A word-addressed register port configures the bank and reads it back. One register starts or stops any subset of counters in the same cycle. A second register clears any subset with a single write. Each counter keeps a sticky overflow flag, which is also visible on a dedicated output.

Software reads a joined pair in two accesses, upper half first. That read copies the lower half into a shadow register. The following read of the lower address returns the shadow copy, so the two halves describe the same instant even if counting continues between the accesses. Live counts are also presented on a flat output bus.

Top module: `ctr_pair_bank`

## Requirements
- R1: After reset every count, every overflow flag, the group-enable and group-clear registers, every chain bit, `reg_rdata` and `reg_rvalid` are zero.
- R2: With its pair not chained, counter i increments by exactly one on each clock edge at which `inc_in[i]` is high and its enable bit is set. A read of its count address (0x20+i) returns the live value.
- R3: Bit i of the group-enable register (address 0x00) gates counter i. Writing several bits starts those counters for increments from the next edge onward. A counter whose bit is clear holds its value.
- R4: Writing address 0x01 with bit i set clears counter i and its overflow flag on the edge after the write. Counters whose bit is 0 keep their value. The register bits clear themselves after one cycle, and a read returns 0. The clear wins over an increment on that same edge.
- R5: A counter's overflow flag (address 0x02 bit i, and `ovf_o[i]`) sets when the counter steps from all ones to zero. It stays set until that counter's count address is read, which clears it. A roll-over coinciding with such a read leaves the flag set.
- R6: Bit 0 of the control register of an even counter 2p (address 0x10+2p) chains counter 2p (low half) with counter 2p+1 (high half). While chained, the high half increments only on an edge where the low half rolls over, provided its own enable bit is set, and it ignores `inc_in[2p+1]`.
- R7: While chained, a read of the high-half address captures the low count into the pair's shadow register on that edge. A later read of the low-half address returns the shadow value, not the live count.
- R8: When a high-half read and a low-half increment meet on the same edge, the shadow keeps the low count from before that increment.
- R9: `reg_rvalid` is high for exactly the cycle after each accepted `reg_rd`, with `reg_rdata` holding the value the state had before that edge.
- R10: When a pair is not chained, a read of the low-half address returns the live count, even after an earlier read of the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| inc_in | input | N | Per-counter increment request |
| count_o | output | N*CW | Live counts, counter i at bits [i*CW +: CW] |
| ovf_o | output | N | Sticky overflow flags |

## Verification
Two pairs of functions can act on the same edge. A read of the high half can coincide with an increment of the low half. A read that clears an overflow flag can coincide with the roll-over that sets it. The bench lines up the read strobe and the increment pulse on one falling edge so that both take effect at the next rising edge. It then checks the following: the returned data, the flag on `ovf_o`, and the shadow value returned by a later low-half read. These must equal the pre-edge count, the flag still set, and the pre-increment low count. It also lines up a pending group clear with an increment and expects a zero count.

// File: rtl/ctr_pair_pkg.sv
package ctr_pair_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;
  localparam logic [REG_AW-1:0] A_GRP_EN   = 8'h00;
  localparam logic [REG_AW-1:0] A_GRP_CLR  = 8'h01;
  localparam logic [REG_AW-1:0] A_OVF      = 8'h02;
  localparam logic [REG_AW-1:0] A_CTL_BASE = 8'h10;
  localparam logic [REG_AW-1:0] A_CNT_BASE = 8'h20;
endpackage

// File: rtl/ctr_cfg_regs.sv
module ctr_cfg_regs
  import ctr_pair_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [N-1:0]      grp_en,
  output logic [N-1:0]      clr_pend,
  output logic [N/2-1:0]    chain_pair
);
  localparam int NP = N / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_en     <= '0;
      clr_pend   <= '0;
      chain_pair <= '0;
    end else begin
      clr_pend <= '0;
      if (wr && addr == A_GRP_EN)  grp_en   <= wdata[N-1:0];
      if (wr && addr == A_GRP_CLR) clr_pend <= wdata[N-1:0];
      for (int p = 0; p < NP; p++) begin
        if (wr && addr == A_CTL_BASE + REG_AW'(2 * p)) chain_pair[p] <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/ctr_cell.sv
module ctr_cell #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          rd_clr,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          wrap
);
  assign wrap = step && !clr && (cnt == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (step) cnt <= cnt + 1'b1;
      if (wrap)        ovf <= 1'b1;
      else if (rd_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/ctr_pair_bank.sv
module ctr_pair_bank
  import ctr_pair_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  input  logic [N-1:0]      inc_in,
  output logic [N*CW-1:0]   count_o,
  output logic [N-1:0]      ovf_o
);
  localparam int NP = N / 2;

  logic [N-1:0]     grp_en, clr_pend, step, rd_clr, wrap;
  logic [NP-1:0]    chain_pair;
  logic [CW-1:0]    cnt_arr [N];
  logic [CW-1:0]    shadow  [NP];
  logic [NP*CW-1:0] shadow_flat;
  logic [31:0]      rd_mux;

  ctr_cfg_regs #(.N(N)) u_cfg (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .grp_en(grp_en), .clr_pend(clr_pend), .chain_pair(chain_pair)
  );

  for (genvar i = 0; i < N; i++) begin : g_ctr
    assign rd_clr[i] = reg_rd && (reg_addr == A_CNT_BASE + 8'(i));
    ctr_cell #(.CW(CW)) u_cell (
      .clk(clk), .rst(rst), .clr(clr_pend[i]), .step(step[i]),
      .rd_clr(rd_clr[i]), .cnt(cnt_arr[i]), .ovf(ovf_o[i]), .wrap(wrap[i])
    );
    assign count_o[i*CW +: CW] = cnt_arr[i];
  end

  for (genvar p = 0; p < NP; p++) begin : g_pair
    assign step[2*p]   = grp_en[2*p] && inc_in[2*p];
    assign step[2*p+1] = grp_en[2*p+1] &&
                         (chain_pair[p] ? wrap[2*p] : inc_in[2*p+1]);
    always_ff @(posedge clk) begin
      if (rst) shadow[p] <= '0;
      else if (chain_pair[p] && rd_clr[2*p+1]) shadow[p] <= cnt_arr[2*p];
    end
    assign shadow_flat[p*CW +: CW] = shadow[p];
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_GRP_EN)  rd_mux[N-1:0] = grp_en;
    if (reg_addr == A_GRP_CLR) rd_mux[N-1:0] = clr_pend;
    if (reg_addr == A_OVF)     rd_mux[N-1:0] = ovf_o;
    for (int i = 0; i < N; i++) begin
      if (reg_addr == A_CTL_BASE + 8'(i) && (i % 2 == 0))
        rd_mux[0] = chain_pair[i/2];
      if (reg_addr == A_CNT_BASE + 8'(i)) begin
        if ((i % 2 == 0) && chain_pair[i/2]) rd_mux = 32'(shadow[i/2]);
        else                                 rd_mux = 32'(cnt_arr[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ctr_pair_bank_chk.sv
module ctr_pair_bank_chk
  import ctr_pair_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [7:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             reg_rvalid,
  input logic [N*CW-1:0]  count_o,
  input logic [N-1:0]     ovf_o,
  input logic [N-1:0]     grp_en,
  input logic [N-1:0]     clr_pend,
  input logic [N/2-1:0]   chain_pair,
  input logic [N/2*CW-1:0] shadow_flat
);
  p_rvalid_set_r9: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
  p_rvalid_clr_r9: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);
  p_en_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (!grp_en[0] && !clr_pend[0]) |=> $stable(count_o[CW-1:0]));
  p_grp_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_GRP_CLR && reg_wdata[0])
      |=> ##1 (count_o[CW-1:0] == '0 && !ovf_o[0]));
  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf_o[0] && !clr_pend[0] && !(reg_rd && reg_addr == A_CNT_BASE))
      |=> ovf_o[0]);
  p_hi_ignores_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (chain_pair[0] && !clr_pend[1] && count_o[CW-1:0] != {CW{1'b1}})
      |=> $stable(count_o[2*CW-1:CW]));
  p_shadow_capture_r7: assert property (@(posedge clk) disable iff (rst)
    (chain_pair[0] && reg_rd && reg_addr == A_CNT_BASE + 8'd1)
      |=> shadow_flat[CW-1:0] == $past(count_o[CW-1:0]));
endmodule

bind ctr_pair_bank ctr_pair_bank_chk #(.N(N), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .count_o(count_o),
  .ovf_o(ovf_o), .grp_en(grp_en), .clr_pend(clr_pend),
  .chain_pair(chain_pair), .shadow_flat(shadow_flat)
);

// File: tb/tb_ctr_pair_bank.sv
module tb_ctr_pair_bank;
  localparam int N  = 8;
  localparam int CW = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            reg_rvalid;
  logic [N-1:0]    inc_in = '0;
  logic [N*CW-1:0] count_o;
  logic [N-1:0]    ovf_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctr_pair_bank #(.N(N), .CW(CW)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .inc_in(inc_in), .count_o(count_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int cnt(input int i);
    return int'(count_o[i*CW +: CW]);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
    check("R9", "rvalid", reg_rvalid, 1);
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); inc_in = m;
    end
    @(negedge clk); inc_in = '0;
  endtask

  task automatic t_reset;
    check("R1", "count0", cnt(0), 0);
    check("R1", "count7", cnt(7), 0);
    check("R1", "ovf", ovf_o, 0);
    check("R1", "rvalid", reg_rvalid, 0);
    check("R1", "rdata", reg_rdata, 0);
  endtask

  task automatic t_independent;
    logic [31:0] d;
    wr(8'h00, 32'h03);
    pulse(8'h03, 1);
    pulse(8'h01, 4);
    pulse(8'h02, 2);
    pulse(8'h04, 4);
    rd(8'h20, d); check("R2", "read count0", d, 5);
    rd(8'h21, d); check("R2", "read count1", d, 3);
    check("R3", "disabled count2", cnt(2), 0);
    rd(8'h00, d); check("R3", "enable readback", d, 3);
    @(negedge clk); check("R9", "rvalid drops", reg_rvalid, 0);
  endtask

  task automatic t_group_clear;
    logic [31:0] d;
    wr(8'h01, 32'h03);
    @(negedge clk);
    check("R4", "count0 cleared", cnt(0), 0);
    check("R4", "count1 cleared", cnt(1), 0);
    rd(8'h01, d); check("R4", "self-clear", d, 0);
    pulse(8'h01, 4);
    pulse(8'h02, 2);
    @(negedge clk); reg_wr = 1; reg_addr = 8'h01; reg_wdata = 32'h01;
    @(negedge clk); reg_wr = 0; inc_in = 8'h01;
    @(negedge clk); inc_in = '0;
    check("R4", "clear beats inc", cnt(0), 0);
    check("R4", "unselected kept", cnt(1), 2);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    pulse(8'h01, 256);
    check("R5", "wrap value", cnt(0), 0);
    check("R5", "flag set", ovf_o[0], 1);
    rd(8'h02, d); check("R5", "ovf register", d & 32'h1, 1);
    rd(8'h20, d); check("R5", "flag cleared by read", ovf_o[0], 0);
    pulse(8'h01, 255);
    @(negedge clk); reg_rd = 1; reg_addr = 8'h20; inc_in = 8'h01;
    @(negedge clk); reg_rd = 0; inc_in = '0;
    check("R5", "read data at wrap", reg_rdata, 255);
    check("R5", "flag kept on coincident wrap", ovf_o[0], 1);
  endtask

  task automatic t_chain;
    wr(8'h01, 32'h03);
    wr(8'h10, 32'h1);
    pulse(8'h03, 255);
    check("R6", "low", cnt(0), 255);
    check("R6", "high ignores own inc", cnt(1), 0);
    pulse(8'h01, 1);
    check("R6", "low wrapped", cnt(0), 0);
    check("R6", "high carry", cnt(1), 1);
  endtask

  task automatic t_shadow;
    logic [31:0] d;
    pulse(8'h01, 10);
    rd(8'h21, d); check("R7", "high read", d, 1);
    pulse(8'h01, 5);
    check("R7", "live low", cnt(0), 15);
    rd(8'h20, d); check("R7", "low returns shadow", d, 10);
    @(negedge clk); reg_rd = 1; reg_addr = 8'h21; inc_in = 8'h01;
    @(negedge clk); reg_rd = 0; inc_in = '0;
    check("R8", "live low after inc", cnt(0), 16);
    rd(8'h20, d); check("R8", "shadow pre-increment", d, 15);
  endtask

  task automatic t_unchain;
    logic [31:0] d;
    wr(8'h10, 32'h0);
    rd(8'h21, d);
    pulse(8'h01, 1);
    rd(8'h20, d); check("R10", "unchained low live", d, 17);
    pulse(8'h02, 1);
    check("R2", "high uses own inc", cnt(1), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_independent();
    t_group_clear();
    t_overflow();
    t_chain();
    t_shadow();
    t_unchain();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule